// File: doc/BRIEF.md
# Byte-Select Write Sequencer for a Multiplexed 16-bit External Bus

This block writes single bytes into a word-wide external memory over a shared address/data bus. A request carries a byte pointer and one data byte. The block first drives the word address on the shared bus with a latch strobe. It then drives the byte on both halves of the bus while pulsing the high write strobe. Byte steering outputs choose which half the memory stores. They suit both SRAM-style parts, which use active-low upper and lower byte enables, and Flash-style parts, which use a byte address line.

The controller is a five-state machine. `ST_IDLE` waits for a request. `ST_ADDR` raises the latch strobe and drives the address. `ST_AHOLD` drops the latch strobe and holds the address for one clock. `ST_DATA` holds the write strobe low for `WR_PULSE` clocks. `ST_RECOV` raises the write strobe, keeps the data on the bus and pulses `done`.

The transitions are: IDLE→ADDR on an accepted request, ADDR→AHOLD and AHOLD→DATA unconditionally, DATA→RECOV when the pulse counter expires, and RECOV→IDLE. The output enable strobe and the low write strobe are never used.

Top module: `bytesel_wr_bus`

## Requirements
- R1: `req_ready` is 1 only in idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1, and `ale` is 1 in the very next cycle.
- R2: `ale` is 1 for exactly one cycle. In that cycle and the next, `ad_out` equals the word address bits `req_ptr[16:1]`.
- R3: While a cycle is active, `a_hi` equals `req_ptr[20:17]` when `addr_wide` is 1, and 0 when it is 0. In idle, `a_hi` is 0.
- R4: Starting two cycles after the `ale` cycle, `wrh_n` is 0 for exactly `WR_PULSE` cycles. During those cycles `ad_out` equals `{data, data}`.
- R5: `wrl_n` and `oe_n` stay 1 at all times.
- R6: During a cycle, if `req_ptr[0]` is 0 then `lb_n`=0, `ub_n`=1 and `ba0`=0. If `req_ptr[0]` is 1 then `ub_n`=0, `lb_n`=1 and `ba0`=1. In idle, `ub_n`=`lb_n`=1 and `ba0`=0.
- R7: After the data phase comes one recovery cycle. In it, `wrh_n` is 1, `ad_out` still shows `{data, data}` and `done` is 1. The cycle after that is idle.
- R8: `ad_oe` is 1 from the `ale` cycle through the recovery cycle and 0 in idle.
- R9: While a cycle is active, changes on `req_valid`, `req_ptr` and `req_data` have no effect on the bus, and `req_ready` stays 0.
- R10: Reset, including reset in the middle of a cycle, returns the block to idle. In idle, `ad_oe`=0, `ale`=0, `wrh_n`=1, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Block can accept a request |
| req_ptr | input | PTR_W | Byte pointer |
| req_data | input | 8 | Byte to write |
| addr_wide | input | 1 | 1: drive the upper address lines |
| ad_out | output | 16 | Shared address/data bus value |
| ad_oe | output | 1 | Bus drive enable |
| a_hi | output | PTR_W-17 | Upper word-address lines |
| ale | output | 1 | Address latch strobe, active high |
| wrh_n | output | 1 | High write strobe, active low |
| wrl_n | output | 1 | Low write strobe, always inactive |
| oe_n | output | 1 | Output enable strobe, always inactive |
| ba0 | output | 1 | Byte address for Flash-style memory |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `addr_wide` is held constant for the length of a write cycle, since it is a configuration input. They also assume that reset is applied for at least one clock edge. The stimulus changes `addr_wide` only while the block is idle. It deliberately changes the pointer, the data and the valid inputs during busy cycles, to show that these inputs are captured only at acceptance. Pointers are chosen with both values of bit 0 and with all-zero and all-one upper bits, so that the byte steering and the upper lines can be seen at their extremes.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AHOLD = 3'd2,
        ST_DATA  = 3'd3,
        ST_RECOV = 3'd4
    } bsw_state_t;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int LANES  = BUS_W / BYTE_W;
endpackage

// File: rtl/bsw_fsm.sv
module bsw_fsm
    import bsw_pkg::*;
#(
    parameter int WR_PULSE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output bsw_state_t state
);
    localparam int CNT_W = $clog2(WR_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_PULSE - 1);

    bsw_state_t       state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (start) state_nx = ST_ADDR;
            end
            ST_ADDR:  state_nx = ST_AHOLD;
            ST_AHOLD: begin
                state_nx = ST_DATA;
                cnt_nx   = '0;
            end
            ST_DATA: begin
                if (cnt_q == CNT_LAST) begin
                    state_nx = ST_RECOV;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            ST_RECOV: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            cnt_q <= cnt_nx;
        end
    end

    // R4: the data phase lasts no longer than the pulse length
    p_data_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && cnt_q == CNT_LAST) |=> (state == ST_RECOV));

    // R1: a new cycle starts only from idle
    p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/bsw_capture.sv
module bsw_capture #(
    parameter int PTR_W  = 21,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              wide_in,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [BYTE_W-1:0] data_q,
    output logic              wide_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            data_q <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            ptr_q  <= ptr_in;
            data_q <= data_in;
            wide_q <= wide_in;
        end
    end
endmodule

// File: rtl/bsw_drive.sv
module bsw_drive
    import bsw_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  bsw_state_t        state,
    input  logic [PTR_W-1:0]  ptr_q,
    input  logic [BYTE_W-1:0] data_q,
    input  logic              wide_q,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic [PTR_W-18:0] a_hi,
    output logic              ale,
    output logic              wrh_n,
    output logic              ba0,
    output logic              ub_n,
    output logic              lb_n,
    output logic              done
);
    localparam int WADDR_W = PTR_W - 1;

    logic [WADDR_W-1:0] waddr;
    logic [BUS_W-1:0]   data_bus;
    logic               busy;

    assign waddr = ptr_q[PTR_W-1:1];

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        assign data_bus[lane*BYTE_W +: BYTE_W] = data_q;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        ale    = 1'b0;
        wrh_n  = 1'b1;
        done   = 1'b0;
        busy   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR: begin
                ad_out = waddr[BUS_W-1:0];
                ad_oe  = 1'b1;
                ale    = 1'b1;
                busy   = 1'b1;
            end
            ST_AHOLD: begin
                ad_out = waddr[BUS_W-1:0];
                ad_oe  = 1'b1;
                busy   = 1'b1;
            end
            ST_DATA: begin
                ad_out = data_bus;
                ad_oe  = 1'b1;
                wrh_n  = 1'b0;
                busy   = 1'b1;
            end
            ST_RECOV: begin
                ad_out = data_bus;
                ad_oe  = 1'b1;
                done   = 1'b1;
                busy   = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        a_hi = (busy && wide_q) ? waddr[WADDR_W-1:BUS_W] : '0;
        ba0  = busy & ptr_q[0];
        ub_n = ~(busy & ptr_q[0]);
        lb_n = ~(busy & ~ptr_q[0]);
    end
endmodule

// File: rtl/bytesel_wr_bus.sv
module bytesel_wr_bus
    import bsw_pkg::*;
#(
    parameter int PTR_W    = 21,
    parameter int WR_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PTR_W-1:0]  req_ptr,
    input  logic [7:0]        req_data,
    input  logic              addr_wide,
    output logic [15:0]       ad_out,
    output logic              ad_oe,
    output logic [PTR_W-18:0] a_hi,
    output logic              ale,
    output logic              wrh_n,
    output logic              wrl_n,
    output logic              oe_n,
    output logic              ba0,
    output logic              ub_n,
    output logic              lb_n,
    output logic              done
);
    bsw_state_t        state;
    logic              start;
    logic [PTR_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] data_q;
    logic              wide_q;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid & req_ready;
    assign wrl_n     = 1'b1;
    assign oe_n      = 1'b1;

    bsw_fsm #(.WR_PULSE(WR_PULSE)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state)
    );

    bsw_capture #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .ptr_in  (req_ptr),
        .data_in (req_data),
        .wide_in (addr_wide),
        .ptr_q   (ptr_q),
        .data_q  (data_q),
        .wide_q  (wide_q)
    );

    bsw_drive #(.PTR_W(PTR_W)) u_drv (
        .state  (state),
        .ptr_q  (ptr_q),
        .data_q (data_q),
        .wide_q (wide_q),
        .ad_out (ad_out),
        .ad_oe  (ad_oe),
        .a_hi   (a_hi),
        .ale    (ale),
        .wrh_n  (wrh_n),
        .ba0    (ba0),
        .ub_n   (ub_n),
        .lb_n   (lb_n),
        .done   (done)
    );

    // R1: an accepted request raises the latch strobe next cycle
    p_accept_ale_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ale);

    // R2: latch strobe is a single-cycle pulse
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4: while writing, both bus halves carry the same byte
    p_lanes_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrh_n |-> (ad_oe && ad_out[15:8] == ad_out[7:0]));

    // R7: the write strobe's rising edge coincides with done
    p_done_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrh_n) |-> done);

    // R8: the bus is released whenever a request can be accepted
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ad_oe);

    // R6: byte steering stays fixed throughout an active cycle
    p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && $past(ad_oe)) |-> ($stable(ba0) && $stable(ub_n) && $stable(lb_n)));

    // R6: exactly one byte enable is active during a cycle
    p_sel_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (ub_n != lb_n));
endmodule

// File: tb/tb_bytesel_wr_bus.sv
module tb_bytesel_wr_bus;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W      = 21;
    localparam int WR_PULSE   = 3;
    localparam int NVEC       = 6;

    // vector: {wide, data, ptr}
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 21'h000000},
        {1'b1, 8'hFF, 21'h1FFFFF},
        {1'b0, 8'h5A, 21'h1ABCD3},
        {1'b1, 8'hA5, 21'h0F0F0E},
        {1'b0, 8'h3C, 21'h012345},
        {1'b1, 8'hC3, 21'h100001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [PTR_W-1:0] req_ptr = '0;
    logic [7:0] req_data = '0;
    logic addr_wide = 1'b0;
    logic [15:0] ad_out;
    logic ad_oe, ale, wrh_n, wrl_n, oe_n, ba0, ub_n, lb_n, done;
    logic [3:0] a_hi;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytesel_wr_bus #(.PTR_W(PTR_W), .WR_PULSE(WR_PULSE)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ptr(req_ptr), .req_data(req_data), .addr_wide(addr_wide),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .wrh_n(wrh_n),
        .wrl_n(wrl_n), .oe_n(oe_n), .ba0(ba0), .ub_n(ub_n), .lb_n(lb_n), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(ad_oe == 1'b0, {tag, " R8 ad_oe"}, 32'(ad_oe), 0);
        chk(req_ready == 1'b1, {tag, " R7 ready"}, 32'(req_ready), 1);
        chk(done == 1'b0, {tag, " R10 done"}, 32'(done), 0);
        chk(ale == 1'b0 && wrh_n == 1'b1, {tag, " R10 strobes"}, {ale, wrh_n}, 32'b01);
        chk({ub_n, lb_n, ba0} == 3'b110, {tag, " R6 idle sel"}, {ub_n, lb_n, ba0}, 32'b110);
        chk(a_hi == 4'h0, {tag, " R3 idle a_hi"}, 32'(a_hi), 0);
        chk(wrl_n && oe_n, {tag, " R5"}, {wrl_n, oe_n}, 32'b11);
    endtask

    task automatic run_write(input logic [20:0] p, input logic [7:0] d, input logic w);
        logic [19:0] wa;
        logic [3:0]  exp_hi;
        logic [2:0]  exp_sel;
        wa      = p[20:1];
        exp_hi  = w ? wa[19:16] : 4'h0;
        exp_sel = p[0] ? 3'b011 : 3'b100;   // {ub_n, lb_n, ba0}
        req_ptr = p; req_data = d; addr_wide = w; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R1 ready before accept", 32'(req_ready), 1);
        @(negedge clk);
        req_ptr = ~p; req_data = ~d;          // R9 junk while busy
        chk(ale == 1'b1, "R1 ale after accept", 32'(ale), 1);
        chk(ad_out == wa[15:0], "R2 addr in ale cycle", 32'(ad_out), 32'(wa[15:0]));
        chk(ad_oe == 1'b1, "R8 oe in addr", 32'(ad_oe), 1);
        chk(a_hi == exp_hi, "R3 a_hi", 32'(a_hi), 32'(exp_hi));
        chk({ub_n, lb_n, ba0} == exp_sel, "R6 sel", {ub_n, lb_n, ba0}, 32'(exp_sel));
        chk(req_ready == 1'b0, "R9 ready low busy", 32'(req_ready), 0);
        chk(wrl_n && oe_n, "R5 strobes", {wrl_n, oe_n}, 32'b11);
        @(negedge clk);
        chk(ale == 1'b0, "R2 ale single", 32'(ale), 0);
        chk(ad_out == wa[15:0], "R2 addr hold", 32'(ad_out), 32'(wa[15:0]));
        chk(wrh_n == 1'b1, "R4 wrh before data", 32'(wrh_n), 1);
        for (int i = 0; i < WR_PULSE; i++) begin
            @(negedge clk);
            chk(wrh_n == 1'b0, "R4 wrh low", 32'(wrh_n), 0);
            chk(ad_out == {d, d}, "R4 R9 data lanes", 32'(ad_out), 32'({d, d}));
            chk(req_ready == 1'b0, "R9 ready low", 32'(req_ready), 0);
            chk({ub_n, lb_n, ba0} == exp_sel, "R6 sel data", {ub_n, lb_n, ba0}, 32'(exp_sel));
            chk(wrl_n == 1'b1, "R5 wrl", 32'(wrl_n), 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(wrh_n == 1'b1, "R7 wrh recover", 32'(wrh_n), 1);
        chk(done == 1'b1, "R7 done", 32'(done), 1);
        chk(ad_out == {d, d}, "R7 data held", 32'(ad_out), 32'({d, d}));
        chk(ad_oe == 1'b1, "R8 oe recover", 32'(ad_oe), 1);
        @(negedge clk);
        chk_idle("after write");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R10 post reset");

        for (int v = 0; v < NVEC; v++) begin
            run_write(VEC[v][20:0], VEC[v][28:21], VEC[v][29]);
        end

        // back-to-back: valid offered in the first idle cycle
        run_write(21'h000002, 8'h81, 1'b1);
        run_write(21'h000003, 8'h18, 1'b0);

        // R10: reset in the middle of a cycle
        req_ptr = 21'h0AAAAB; req_data = 8'h77; addr_wide = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(wrh_n == 1'b0, "R4 midcycle wrh low", 32'(wrh_n), 0);
        rst_n = 1'b0;
        #1;
        chk(ad_oe == 1'b0 && wrh_n == 1'b1, "R10 async reset", {ad_oe, wrh_n}, 32'b01);
        @(negedge clk);
        chk_idle("R10 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        run_write(21'h1FFFFE, 8'h42, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule